// File: doc/BRIEF.md
# Frame Sync Pattern Detector

This block sits behind the receive demodulator of a narrowband data modem. It watches the demodulated bit stream, which arrives together with a recovered bit clock, and searches that stream for one of two programmable 16-bit frame synchronization words. Optionally, the word must be directly preceded by a 4-bit alternating bit-sync prefix. The bit clock is sampled into the block's own system clock domain. A received bit is taken on each rising edge of the bit clock, and the frame-detect flag and the data output are updated on each falling edge.

When detection is enabled, the flag starts low. While it is low, the data and clock outputs are forced high so that downstream logic sees an idle line. When the sync word arrives, the flag rises and stays high until detection is disabled or the power-down reset is applied. The data and clock outputs then follow the line. When detection is disabled, the flag is held low and the data and clock pass through unmasked.

Top module: `fsd_top`

## Requirements
- R1: With the prefix option low (`pre_i`=0), the detector compares the 16 most recent bits. Bits enter MSB first, and the newest bit is the least significant bit. The word is 16'h9336 for `sel_i`=0 and 16'hC4D6 for `sel_i`=1.
- R2: With `pre_i`=1, the detector compares the 20 most recent bits against the prefix 4'b1010 followed by the word: 20'hA9336 for `sel_i`=0 and 20'hAC4D6 for `sel_i`=1.
- R3: While `en_i`=0, `fd_o` is 0 from the next system clock onward. `rd_o` carries the bit most recently shifted in, as captured at the last falling edge of the bit clock. `rclk_o` follows the bit clock, delayed by one system clock.
- R4: While `en_i`=1 and `fd_o`=0, both `rd_o` and `rclk_o` are 1.
- R5: A match seen at a falling bit clock edge while `en_i`=1 sets `fd_o` to 1. It then stays 1 through further bits, whether they match or not. A second match has no visible effect.
- R6: `fd_o` and the registered data behind `rd_o` change only in response to a falling edge of the bit clock, two system clocks after the input edge. Clearing by `en_i` or by reset is the exception.
- R7: After reset, `fd_o`=0, the shift register holds zeros and the registered data bit is 1.
- R8: In prefix mode the 16-bit word alone, preceded by anything other than 1010, does not set `fd_o`.
- R9: Dropping `en_i` clears `fd_o`. Raising `en_i` again re-arms detection, so `fd_o` rises only while `en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| pd_rst_n | input | 1 | Asynchronous active-low power-down reset |
| bclk_i | input | 1 | Recovered receive bit clock |
| rxb_i | input | 1 | Demodulated receive bit |
| en_i | input | 1 | Frame detection enable |
| sel_i | input | 1 | Sync word select (0: 9336h, 1: C4D6h) |
| pre_i | input | 1 | Require the 1010 bit-sync prefix before the word |
| fd_o | output | 1 | Sticky frame-detect flag |
| rd_o | output | 1 | Receive data, held at 1 while masked |
| rclk_o | output | 1 | Receive bit clock, held at 1 while masked |

## Verification
The hardest situation to reach from the ports is a second arrival of the sync word while the flag is already set, or a word that lands just after the enable is re-raised. Random bits almost never form a 16- or 20-bit word by chance. The stimulus therefore injects complete words at random points into a random bit stream, and it toggles the enable, the word select and the prefix option between bits. A directed sequence feeds the bare 16-bit word in prefix mode, which must not be detected, and then feeds the full prefixed word, which must be.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    localparam int unsigned SYNC_W_DEF = 16;
    localparam int unsigned PRE_W_DEF  = 4;

    typedef struct packed {
        logic bclk;
        logic bclk_prev;
        logic bitv;
    } edge_st_t;

    typedef struct packed {
        logic flag;
        logic data;
    } track_st_t;
endpackage

// File: rtl/fsd_edge_sense.sv
module fsd_edge_sense
    import fsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic rxb_i,
    output logic bclk_o,
    output logic rise_o,
    output logic fall_o,
    output logic bit_o
);
    edge_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.bclk      = bclk_i;
        st_d.bclk_prev = st_q.bclk;
        st_d.bitv      = rxb_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o = st_q.bclk;
    assign rise_o = st_q.bclk & ~st_q.bclk_prev;
    assign fall_o = ~st_q.bclk & st_q.bclk_prev;
    assign bit_o  = st_q.bitv;
endmodule

// File: rtl/fsd_shift_match.sv
module fsd_shift_match #(
    parameter int unsigned          SYNC_W = 16,
    parameter int unsigned          PRE_W  = 4,
    parameter logic [SYNC_W-1:0]    WORD_A = 16'h9336,
    parameter logic [SYNC_W-1:0]    WORD_B = 16'hC4D6,
    parameter logic [PRE_W-1:0]     PREFIX = 4'hA
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_i,
    input  logic bit_i,
    input  logic sel_i,
    input  logic pre_i,
    output logic match_o,
    output logic last_bit_o
);
    localparam int unsigned TOT_W = SYNC_W + PRE_W;

    logic [TOT_W-1:0]  sr_d, sr_q;
    logic [SYNC_W-1:0] word;
    logic              hit_short, hit_long;

    always_comb begin
        sr_d = sr_q;
        if (shift_i) sr_d = {sr_q[TOT_W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    always_comb begin
        word      = sel_i ? WORD_B : WORD_A;
        hit_short = (sr_q[SYNC_W-1:0] == word);
        hit_long  = (sr_q == {PREFIX, word});
        match_o   = pre_i ? hit_long : hit_short;
    end

    assign last_bit_o = sr_q[0];
endmodule

// File: rtl/fsd_frame_track.sv
module fsd_frame_track
    import fsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fall_i,
    input  logic match_i,
    input  logic last_bit_i,
    output logic flag_o,
    output logic data_o
);
    track_st_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        if (fall_i) begin
            tr_d.data = last_bit_i;
            if (en_i && match_i) tr_d.flag = 1'b1;
        end
        if (!en_i) tr_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '{flag: 1'b0, data: 1'b1};
        else        tr_q <= tr_d;
    end

    assign flag_o = tr_q.flag;
    assign data_o = tr_q.data;
endmodule

// File: rtl/fsd_top.sv
module fsd_top
    import fsd_pkg::*;
#(
    parameter int unsigned       SYNC_W = SYNC_W_DEF,
    parameter int unsigned       PRE_W  = PRE_W_DEF,
    parameter logic [SYNC_W-1:0] WORD_A = 16'h9336,
    parameter logic [SYNC_W-1:0] WORD_B = 16'hC4D6,
    parameter logic [PRE_W-1:0]  PREFIX = 4'hA
) (
    input  logic clk,
    input  logic pd_rst_n,
    input  logic bclk_i,
    input  logic rxb_i,
    input  logic en_i,
    input  logic sel_i,
    input  logic pre_i,
    output logic fd_o,
    output logic rd_o,
    output logic rclk_o
);
    logic bclk_s, rise, fall, bit_s, match, last_bit, flag, data;
    logic mask;

    fsd_edge_sense u_edge (
        .clk    (clk),
        .rst_n  (pd_rst_n),
        .bclk_i (bclk_i),
        .rxb_i  (rxb_i),
        .bclk_o (bclk_s),
        .rise_o (rise),
        .fall_o (fall),
        .bit_o  (bit_s)
    );

    fsd_shift_match #(
        .SYNC_W (SYNC_W),
        .PRE_W  (PRE_W),
        .WORD_A (WORD_A),
        .WORD_B (WORD_B),
        .PREFIX (PREFIX)
    ) u_match (
        .clk        (clk),
        .rst_n      (pd_rst_n),
        .shift_i    (rise),
        .bit_i      (bit_s),
        .sel_i      (sel_i),
        .pre_i      (pre_i),
        .match_o    (match),
        .last_bit_o (last_bit)
    );

    fsd_frame_track u_track (
        .clk        (clk),
        .rst_n      (pd_rst_n),
        .en_i       (en_i),
        .fall_i     (fall),
        .match_i    (match),
        .last_bit_i (last_bit),
        .flag_o     (flag),
        .data_o     (data)
    );

    always_comb begin
        mask   = en_i & ~flag;
        fd_o   = flag;
        rd_o   = mask ? 1'b1 : data;
        rclk_o = mask ? 1'b1 : bclk_s;
    end
endmodule

// File: rtl/fsd_top_chk.sv
module fsd_top_chk (
    input logic clk,
    input logic pd_rst_n,
    input logic bclk_i,
    input logic en_i,
    input logic fd_o
);
    // R3
    fd_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!pd_rst_n)
        !en_i |=> !fd_o);

    // R5
    fd_sticky_chk: assert property (@(posedge clk) disable iff (!pd_rst_n)
        (fd_o && en_i) |=> fd_o);

    // R6
    fd_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!pd_rst_n)
        $rose(fd_o) |-> (!$past(bclk_i, 2) && $past(bclk_i, 3)));

    // R9
    fd_rise_needs_en_chk: assert property (@(posedge clk) disable iff (!pd_rst_n)
        $rose(fd_o) |-> $past(en_i));
endmodule

bind fsd_top fsd_top_chk u_chk (
    .clk      (clk),
    .pd_rst_n (pd_rst_n),
    .bclk_i   (bclk_i),
    .en_i     (en_i),
    .fd_o     (fd_o)
);

// File: tb/fsd_top_tb_top.sv
module fsd_top_tb_top;
    logic clk = 1'b0;
    logic pd_rst_n = 1'b0;
    logic bclk = 1'b0, rxb = 1'b0, en = 1'b0, sel = 1'b0, pre = 1'b0;
    logic fd, rd, rclk;

    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    logic [19:0] m_sr   = '0;
    logic        m_flag = 1'b0;
    logic        m_data = 1'b1;
    bit          m_hi   = 1'b0;

    always #2 clk = ~clk;

    fsd_top dut_i (
        .clk(clk), .pd_rst_n(pd_rst_n), .bclk_i(bclk), .rxb_i(rxb),
        .en_i(en), .sel_i(sel), .pre_i(pre),
        .fd_o(fd), .rd_o(rd), .rclk_o(rclk)
    );

    function automatic bit exp_match(logic [19:0] sr, logic s, logic p);
        logic [15:0] w;
        w = s ? 16'hC4D6 : 16'h9336;
        return p ? (sr == {4'hA, w}) : (sr[15:0] == w);
    endfunction

    function automatic string tag_now();
        if (!en)         return "R3";
        else if (!m_flag) return "R4";
        else              return "R5";
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        bclk = 1'b0;
        rxb  = b;
        if (m_hi) begin
            if (en && exp_match(m_sr, sel, pre)) m_flag = 1'b1;
            m_data = m_sr[0];
        end
        if (!en) m_flag = 1'b0;
        m_hi = 1'b0;
        repeat (4) @(negedge clk);
        check(tag_now(), "fd (R6 edge timing)", fd, m_flag);
        check(tag_now(), "rd", rd, (en && !m_flag) ? 1'b1 : m_data);
        check(tag_now(), "rclk low phase", rclk, (en && !m_flag) ? 1'b1 : 1'b0);
        bclk = 1'b1;
        m_hi = 1'b1;
        repeat (4) @(negedge clk);
        m_sr = {m_sr[18:0], b};
        check("R6", "fd stable on rising bit clock", fd, m_flag);
        check("R6", "rd stable on rising bit clock", rd, (en && !m_flag) ? 1'b1 : m_data);
        check(tag_now(), "rclk high phase", rclk, 1'b1);
    endtask

    task automatic send_word(logic [19:0] w, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic send_rand(int n);
        for (int i = 0; i < n; i++) send_bit(1'($urandom));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0f5d));
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7", "fd after reset", fd, 1'b0);
        check("R7", "rd after reset", rd, 1'b1);
        pd_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7", "fd after release", fd, 1'b0);

        // R3: pass-through while disabled
        send_rand(24);
        send_word(20'h09336, 16);
        send_rand(4);
        check("R3", "fd with detection off", fd, 1'b0);

        // R1: 16-bit word, select 0, then sticky R5
        en = 1'b1; sel = 1'b0; pre = 1'b0;
        send_rand(20);
        send_word(20'h09336, 16);
        send_bit(1'b0);
        check("R1", "fd after 9336", fd, 1'b1);
        send_rand(12);
        send_word(20'h09336, 16);   // R5: second match no effect
        send_bit(1'b1);
        check("R5", "fd after second match", fd, 1'b1);

        // R9: drop and re-raise enable
        en = 1'b0;
        send_bit(1'b0);
        check("R9", "fd cleared by enable low", fd, 1'b0);
        en = 1'b1; sel = 1'b1; pre = 1'b1;
        // R8: bare word in prefix mode is not a frame
        send_word(20'h00000, 8);
        send_word(20'h0C4D6, 16);
        send_bit(1'b0);
        check("R8", "fd with bare word in prefix mode", fd, 1'b0);
        // R2: prefixed word
        send_word(20'hAC4D6, 20);
        send_bit(1'b0);
        check("R2", "fd after AC4D6", fd, 1'b1);
        en = 1'b0;
        send_bit(1'b1);
        en = 1'b1; sel = 1'b0;
        send_word(20'hA9336, 20);
        send_bit(1'b1);
        check("R2", "fd after A9336", fd, 1'b1);

        // R7: power-down reset mid-stream
        @(negedge clk);
        pd_rst_n = 1'b0;
        @(negedge clk);
        check("R7", "fd during reset", fd, 1'b0);
        pd_rst_n = 1'b1;
        bclk = 1'b0;
        m_sr = '0; m_flag = 1'b0; m_data = 1'b1; m_hi = 1'b0;
        repeat (2) @(negedge clk);

        // random mix with injected words
        for (int k = 0; k < 160; k++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r == 0) en  = ~en;
            if (r == 1) sel = 1'($urandom);
            if (r == 2) pre = 1'($urandom);
            send_rand(int'($urandom_range(1, 6)));
            if ($urandom_range(0, 2) == 0)
                send_word(sel ? 20'hAC4D6 : 20'hA9336, 20);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule